// File: doc/BRIEF.md
# PWM Sample Write Buffer

This block sits between a register bus and the compare stage of a FIFO-fed pulse-width modulator. Software writes 32-bit words to a sample address. The block picks one 16-bit half of each word, can reverse the two bytes of that half, and queues the result in a four-deep FIFO. The compare stage takes samples one at a time through a valid/pop pair, and the head sample is always visible on `sample_o`.

Software can read a status word that holds the current fill level. It also holds a "FIFO low" flag, computed from the number of free slots against a programmable watermark, and a sticky write-error flag. The write-error flag is set by any write that the full FIFO cannot take. Each of the two flags has its own enable in an interrupt-enable register. The single interrupt line is the OR of the enabled flags.

Register map, on a 2-bit address: 0 is control, 1 is interrupt enable, 2 is status, and 3 is the sample port. A write to address 3 pushes a sample. A read of address 3 returns the head sample.

Top module: `pwm_sample_fifo`

## Requirements
- R1: The FIFO holds up to four 16-bit samples and returns them in write order. Status bits [2:0] report the fill level, from 0 to 4.
- R2: Control bit 2 selects the half. When it is 1, bits [31:16] of the written word form the sample. When it is 0, bits [15:0] form the sample.
- R3: Control bit 3 reverses the two bytes of the selected half before it is stored. This reversal is applied after the half selection of R2.
- R4: Control bits [1:0] hold a watermark value k, reset value 1. Status bit 3 is 1 exactly when the number of free slots (4 minus the fill level) is at least k+1.
- R5: A sample write while the FIFO holds 4 entries, with no pop in the same cycle, is dropped. The stored samples and the fill level stay unchanged, and status bit 4 (write error) becomes 1.
- R6: Status bit 4 stays set until a status write with bit 4 at 1 clears it. A status write with bit 4 at 0 leaves it unchanged.
- R7: `irq_o` is 1 exactly when (status bit 3 and enable bit 0) or (status bit 4 and enable bit 1).
- R8: `sample_valid_o` is 1 when the fill level is non-zero, and `sample_o` shows the oldest sample. A pop while the FIFO is empty changes nothing.
- R9: A sample write and a pop in the same cycle are both honoured. With a full FIFO the write is accepted, the level stays 4 and no error is flagged. With an empty FIFO the pop is ignored and the level becomes 1.
- R10: After reset the fill level is 0, the write error is 0, control reads 0x1 and the interrupt enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| pop_i | input | 1 | Compare stage takes the head sample |
| sample_o | output | 16 | Head sample |
| sample_valid_o | output | 1 | FIFO not empty |
| irq_o | output | 1 | Combined interrupt |

## Verification
A sample write from the bus and a pop from the compare stage can land in the same cycle. This is the case where the full test and the empty test decide whether either side is lost. The bench fills the FIFO to four entries, then drives a write and a pop in one cycle, and expects the level to stay 4 with no error flag. Draining the FIFO must then return the last three old samples followed by the new one. It repeats the collision on an empty FIFO and expects a level of 1, with the written value at the head.

// File: rtl/pwm_sfifo_pkg.sv
package pwm_sfifo_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_IRQEN  = 2'd1,
    REG_STAT   = 2'd2,
    REG_SAMPLE = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_HSWAP_BIT = 2;
  localparam int unsigned CTRL_BSWAP_BIT = 3;
  localparam int unsigned IRQ_LOW_BIT    = 0;
  localparam int unsigned IRQ_WERR_BIT   = 1;
endpackage

// File: rtl/pwm_sfifo_swap.sv
module pwm_sfifo_swap #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 16
) (
  input  logic [DW-1:0] data_i,
  input  logic          hswap_i,
  input  logic          bswap_i,
  output logic [SW-1:0] sample_o
);
  localparam int unsigned NB = SW / 8;

  logic [SW-1:0] half;
  logic [SW-1:0] rev;

  assign half = hswap_i ? data_i[DW-1 -: SW] : data_i[SW-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign rev[b*8 +: 8] = half[(NB-1-b)*8 +: 8];
  end

  assign sample_o = bswap_i ? rev : half;
endmodule

// File: rtl/pwm_sfifo_store.sv
module pwm_sfifo_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SW    = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [SW-1:0]    data_i,
  input  logic             pop_i,
  output logic [SW-1:0]    head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             overflow_o
);
  logic [SW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             full, empty, push_ok, pop_ok;

  assign full       = (count_q == CNT_W'(DEPTH));
  assign empty      = (count_q == '0);
  assign pop_ok     = pop_i & ~empty;
  // a pop in the same cycle frees the slot a full FIFO needs
  assign push_ok    = push_i & (~full | pop_ok);
  assign overflow_o = push_i & ~push_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wr_ptr_q] <= data_i;
        wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      end
      if (pop_ok)
        rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  p_level_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_drop_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> (count_q == CNT_W'(DEPTH)) && $stable(rd_ptr_q) && $stable(wr_ptr_q));
  p_pop_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> (count_q == '0) && $stable(rd_ptr_q));
  p_collide_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full) |=> count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/pwm_sfifo_status.sv
module pwm_sfifo_status #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned WM_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [WM_W-1:0]  wm_i,
  input  logic             werr_set_i,
  input  logic             werr_clr_i,
  input  logic [1:0]       irq_en_i,
  output logic             low_o,
  output logic             werr_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] free_slots;
  logic             werr_q;

  assign free_slots = CNT_W'(DEPTH) - count_i;
  assign low_o      = (int'(free_slots) >= int'(wm_i) + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         werr_q <= 1'b0;
    else if (werr_set_i) werr_q <= 1'b1;
    else if (werr_clr_i) werr_q <= 1'b0;
  end

  assign werr_o = werr_q;
  assign irq_o  = (low_o & irq_en_i[0]) | (werr_q & irq_en_i[1]);

  p_werr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    werr_set_i |=> werr_q);
  p_werr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (werr_q && !werr_clr_i) |=> werr_q);
  p_werr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (werr_clr_i && !werr_set_i) |=> !werr_q);
endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo
  import pwm_sfifo_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned SW       = 16,
  parameter int unsigned WM_RESET = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          pop_i,
  output logic [SW-1:0] sample_o,
  output logic          sample_valid_o,
  output logic          irq_o
);
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
  localparam int unsigned WM_W     = $clog2(DEPTH);
  localparam int unsigned LOW_BIT  = CNT_W;
  localparam int unsigned WERR_BIT = CNT_W + 1;

  logic [WM_W-1:0]  wm_q;
  logic             hswap_q, bswap_q;
  logic [1:0]       irq_en_q;
  logic             push, werr_clr, overflow, low, werr;
  logic [SW-1:0]    in_sample, head;
  logic [CNT_W-1:0] count;

  assign push     = wr_en_i & (wr_addr_i == REG_SAMPLE);
  assign werr_clr = wr_en_i & (wr_addr_i == REG_STAT) & wr_data_i[WERR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_q     <= WM_W'(WM_RESET);
      hswap_q  <= 1'b0;
      bswap_q  <= 1'b0;
      irq_en_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_CTRL) begin
        wm_q    <= wr_data_i[WM_W-1:0];
        hswap_q <= wr_data_i[CTRL_HSWAP_BIT];
        bswap_q <= wr_data_i[CTRL_BSWAP_BIT];
      end
      if (wr_addr_i == REG_IRQEN) irq_en_q <= wr_data_i[1:0];
    end
  end

  pwm_sfifo_swap #(.DW(DW), .SW(SW)) u_swap (
    .data_i   (wr_data_i),
    .hswap_i  (hswap_q),
    .bswap_i  (bswap_q),
    .sample_o (in_sample)
  );

  pwm_sfifo_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .data_i     (in_sample),
    .pop_i      (pop_i),
    .head_o     (head),
    .count_o    (count),
    .overflow_o (overflow)
  );

  pwm_sfifo_status #(.DEPTH(DEPTH)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count),
    .wm_i       (wm_q),
    .werr_set_i (overflow),
    .werr_clr_i (werr_clr),
    .irq_en_i   (irq_en_q),
    .low_o      (low),
    .werr_o     (werr),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      REG_CTRL: begin
        rd_data_o[WM_W-1:0]      = wm_q;
        rd_data_o[CTRL_HSWAP_BIT] = hswap_q;
        rd_data_o[CTRL_BSWAP_BIT] = bswap_q;
      end
      REG_IRQEN: rd_data_o[1:0] = irq_en_q;
      REG_STAT: begin
        rd_data_o[CNT_W-1:0] = count;
        rd_data_o[LOW_BIT]   = low;
        rd_data_o[WERR_BIT]  = werr;
      end
      default: rd_data_o[SW-1:0] = head;
    endcase
  end

  assign sample_o       = head;
  assign sample_valid_o = (count != '0);

  p_valid_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && !pop_i && !push) |=> sample_valid_o && $stable(sample_o));
  p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_q == 2'b00) |-> !irq_o);
endmodule

// File: tb/pwm_sample_fifo_tb.sv
module pwm_sample_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        pop = 1'b0;
  logic [15:0] sample;
  logic        sample_valid;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_IEN = 2'd1, A_STAT = 2'd2, A_SMP = 2'd3;

  always #2 clk = ~clk;

  pwm_sample_fifo u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pop_i(pop), .sample_o(sample), .sample_valid_o(sample_valid), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] stat(input int lvl, input int wm, input bit werr);
    bit low = ((4 - lvl) >= wm + 1);
    return {27'd0, werr, low, 3'(lvl)};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(A_STAT, d); chk("R10 status", d, 32'h08);
    rd(A_CTRL, d); chk("R10 ctrl", d, 32'h1);
    rd(A_IEN, d);  chk("R10 irqen", d, 32'h0);
    chk("R10 valid", {31'd0, sample_valid}, 32'd0);
    chk("R10 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      bus_wr(A_SMP, 32'hFFFF_0000 | (32'h1111 * (i + 1)));
      rd(A_STAT, d); chk("R1 level", d, stat(i + 1, 1, 0));
    end
    for (int i = 0; i < 4; i++) begin
      chk("R8 valid", {31'd0, sample_valid}, 32'd1);
      chk("R1 order", {16'd0, sample}, 32'h1111 * (i + 1));
      rd(A_SMP, d); chk("R1 read port", d, 32'h1111 * (i + 1));
      do_pop();
    end
    rd(A_STAT, d); chk("R1 drained", d, stat(0, 1, 0));
  endtask

  task automatic t_swap();
    bus_wr(A_CTRL, 32'h5);
    bus_wr(A_SMP, 32'hABCD_1234);
    chk("R2 upper half", {16'd0, sample}, 32'hABCD);
    do_pop();
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_SMP, 32'hABCD_1234);
    chk("R2 lower half", {16'd0, sample}, 32'h1234);
    do_pop();
    bus_wr(A_CTRL, 32'h9);
    bus_wr(A_SMP, 32'hABCD_1234);
    chk("R3 byte swap", {16'd0, sample}, 32'h3412);
    do_pop();
    bus_wr(A_CTRL, 32'hD);
    bus_wr(A_SMP, 32'hABCD_1234);
    chk("R3 both swaps", {16'd0, sample}, 32'hCDAB);
    do_pop();
    bus_wr(A_CTRL, 32'h1);
  endtask

  task automatic t_watermark();
    logic [31:0] d;
    for (int wm = 0; wm < 4; wm++) begin
      bus_wr(A_CTRL, 32'(wm));
      for (int lvl = 0; lvl <= 4; lvl++) begin
        rd(A_STAT, d); chk("R4 low flag", d, stat(lvl, wm, 0));
        if (lvl < 4) bus_wr(A_SMP, 32'(lvl));
      end
      for (int i = 0; i < 4; i++) do_pop();
    end
    bus_wr(A_CTRL, 32'h1);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) bus_wr(A_SMP, 32'hA0 + 32'(i));
    bus_wr(A_SMP, 32'hBEEF);
    rd(A_STAT, d); chk("R5 error set, level kept", d, stat(4, 1, 1));
    for (int i = 0; i < 4; i++) begin
      chk("R5 contents kept", {16'd0, sample}, 32'hA0 + 32'(i));
      do_pop();
    end
    rd(A_STAT, d); chk("R5 drained, error sticky", d, stat(0, 1, 1));
    bus_wr(A_STAT, 32'h0F);
    rd(A_STAT, d); chk("R6 write 0 no effect", d, stat(0, 1, 1));
    bus_wr(A_STAT, 32'h10);
    rd(A_STAT, d); chk("R6 write 1 clears", d, stat(0, 1, 0));
  endtask

  task automatic t_irq();
    bus_wr(A_IEN, 32'h1);
    chk("R7 low enabled", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 4; i++) bus_wr(A_SMP, 32'(i));
    chk("R7 low gone", {31'd0, irq}, 32'd0);
    bus_wr(A_SMP, 32'h55);
    chk("R7 error not enabled", {31'd0, irq}, 32'd0);
    bus_wr(A_IEN, 32'h2);
    chk("R7 error enabled", {31'd0, irq}, 32'd1);
    bus_wr(A_STAT, 32'h10);
    chk("R7 error cleared", {31'd0, irq}, 32'd0);
    bus_wr(A_IEN, 32'h0);
    for (int i = 0; i < 4; i++) do_pop();
  endtask

  task automatic t_pop_empty();
    logic [31:0] d;
    do_pop();
    rd(A_STAT, d); chk("R8 pop on empty", d, stat(0, 1, 0));
    chk("R8 valid low", {31'd0, sample_valid}, 32'd0);
    bus_wr(A_SMP, 32'h7777);
    chk("R8 head after pop on empty", {16'd0, sample}, 32'h7777);
    do_pop();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) bus_wr(A_SMP, 32'hC0 + 32'(i));
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_SMP; wr_data = 32'hC4; pop = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pop = 1'b0;
    rd(A_STAT, d); chk("R9 full collide", d, stat(4, 1, 0));
    for (int i = 1; i <= 4; i++) begin
      chk("R9 order after collide", {16'd0, sample}, 32'hC0 + 32'(i));
      do_pop();
    end
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_SMP; wr_data = 32'hD1; pop = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pop = 1'b0;
    rd(A_STAT, d); chk("R9 empty collide", d, stat(1, 1, 0));
    chk("R9 empty collide head", {16'd0, sample}, 32'hD1);
    do_pop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_swap();
    t_watermark();
    t_overflow();
    t_irq();
    t_pop_empty();
    t_collide();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule